// File: doc/BRIEF.md
# Shared-Scale Block Dot Product

This unit forms the dot product of two blocks of numbers that each carry one shared power-of-two scale. A block is an 8-bit biased scale exponent plus K small signed integer elements, and the number each element stands for is the element times two raised to the unbiased scale. The unit multiplies the matching elements of the two blocks, adds all K products exactly in a fixed-point adder, and applies the scales once at the end by adding the two exponents. The result leaves as an unnormalised signed fixed-point sum with a signed exponent, so its value is `out_sum * 2^out_exp`.

Longer vectors are split into consecutive groups of K contiguous elements per operand and fed one block pair per beat. Holding `in_last` low chains the beats into one running result. Each new block result is aligned to the running sum by an arithmetic right shift of whichever side has the smaller exponent. Only the beat with `in_last` high produces an output. A scale code of all ones marks a block as not-a-number, and the flag travels with the result.

Top module: `mxdot_unit`

## Requirements
- R1: For a group of one block (`in_last`=1), `out_sum` equals the exact sum over i of A[i]*B[i]. Element i of each operand is the 8-bit two's complement value at bits [8i+7:8i] of `in_elem_a` / `in_elem_b`.
- R2: `out_exp` is the signed 10-bit value `in_scale_a + in_scale_b - 254`. This holds at both extremes: codes 0,0 give -254 and codes 254,254 give +254.
- R3: Full-range elements never overflow the sum. All elements -128 in both operands give +524288, and A all -128 with B all 127 gives -520192.
- R4: A scale code of 255 on either operand sets `out_nan`. A code of 254 is an ordinary scale and leaves `out_nan` at 0.
- R5: With `out_ready` held high, `out_valid` rises after the third rising clock edge, counting the edge that accepts the beat as the first. It is still low after the second edge.
- R6: Beats with `in_last`=0 produce no output. A group gives exactly one `out_valid` beat, on its `in_last`=1 block.
- R7: Within a group, the running sum and the new block sum are combined by arithmetic right shift (floor) of the side with the smaller exponent, by the exponent difference, followed by an add. The result keeps the larger exponent. When the exponents are equal, the add is exact.
- R8: `out_nan` is set if any block in the group had a 255 scale code. The next group starts clear.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_valid`, `out_sum`, `out_exp`, `out_nan` hold their values. The result is delivered once `out_ready` rises.
- R10: After reset, `out_valid`=0 and `in_ready`=1. Any group in progress is dropped, so the next block starts a fresh result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Block pair offered |
| in_ready | output | 1 | Block pair accepted when high together with in_valid |
| in_last | input | 1 | Block pair closes the current group |
| in_scale_a | input | 8 | Biased scale exponent of operand A (255 = NaN) |
| in_scale_b | input | 8 | Biased scale exponent of operand B (255 = NaN) |
| in_elem_a | input | 256 | K=32 signed 8-bit elements of A, element i at [8i+7:8i] |
| in_elem_b | input | 256 | K=32 signed 8-bit elements of B, same layout |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | 29 | Signed fixed-point sum |
| out_exp | output | 10 | Signed result exponent |
| out_nan | output | 1 | Group contained a NaN block |

## Verification
The single-block table tries several input patterns, and each one separates a different fault:
- a ramp-against-ramp pattern, which catches mixed-up signs;
- all -128 in both operands, and -128 against 127, which expose a product or sum width that is too narrow;
- alternating signs, which catch a missing sign extension;
- a single nonzero lane at element 0 and another at element 31, which show whether the lanes are sliced in the right place.

Scale pairs at both exponent extremes and codes 254 and 255 tell a correct bias and NaN decode apart from an off-by-one. Chained groups with a smaller new exponent, a larger new exponent and equal exponents separate the two shift directions from an exact add, and a NaN inside a group shows that the flag is sticky. A reset in mid-group and a held `out_ready` show that a stale running sum is dropped and that a stalled result is neither lost nor altered.

// File: rtl/mxdot_pkg.sv
package mxdot_pkg;
  // width of an exact sum of k products of two ew-bit signed values
  function automatic int sum_width(int k, int ew);
    return 2 * ew + $clog2(k);
  endfunction

  // signed exponent width able to hold the sum of two biased codes minus the bias
  function automatic int exp_width(int sw);
    return sw + 2;
  endfunction
endpackage

// File: rtl/mxdot_mul.sv
module mxdot_mul #(
  parameter int K  = 32,
  parameter int EW = 8,
  parameter int SW = 8,
  parameter int XW = 10,
  localparam int PW = 2 * EW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 in_fire,
  input  logic                 in_last,
  input  logic [SW-1:0]        scale_a,
  input  logic [SW-1:0]        scale_b,
  input  logic [K*EW-1:0]      elem_a,
  input  logic [K*EW-1:0]      elem_b,
  output logic                 s1_valid,
  output logic                 s1_last,
  output logic                 s1_nan,
  output logic signed [XW-1:0] s1_exp,
  output logic [K*PW-1:0]      s1_prod
);
  localparam int BIAS = (1 << (SW - 1)) - 1;
  localparam logic signed [XW-1:0] BIAS2 = XW'(2 * BIAS);

  logic signed [XW-1:0] exp_sum;
  assign exp_sum = $signed({{(XW-SW){1'b0}}, scale_a})
                 + $signed({{(XW-SW){1'b0}}, scale_b}) - BIAS2;

  always_ff @(posedge clk) begin
    if (rst)     s1_valid <= 1'b0;
    else if (en) s1_valid <= in_fire;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s1_last <= in_last;
      s1_nan  <= (&scale_a) | (&scale_b);
      s1_exp  <= exp_sum;
    end
  end

  // one signed multiplier per lane
  for (genvar g = 0; g < K; g++) begin : g_lane
    logic signed [EW-1:0] ea, eb;
    logic signed [PW-1:0] prod;
    assign ea   = elem_a[g*EW +: EW];
    assign eb   = elem_b[g*EW +: EW];
    assign prod = PW'(ea) * PW'(eb);
    always_ff @(posedge clk) begin
      if (en) s1_prod[g*PW +: PW] <= prod;
    end
  end

  // R4: an all-ones scale code on an accepted beat marks the stage as NaN
  a_r4_nan_flag: assert property (@(posedge clk) disable iff (rst)
    (en && in_fire && ((&scale_a) || (&scale_b))) |=> (s1_valid && s1_nan));

  // R2: an ordinary result exponent stays inside +/- twice the bias
  a_r2_exp_range: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_nan) |-> (s1_exp <= BIAS2 && s1_exp >= -BIAS2));
endmodule

// File: rtl/mxdot_sum.sv
module mxdot_sum #(
  parameter int K     = 32,
  parameter int EW    = 8,
  parameter int XW    = 10,
  parameter int SUM_W = 21,
  localparam int PW = 2 * EW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    s1_valid,
  input  logic                    s1_last,
  input  logic                    s1_nan,
  input  logic signed [XW-1:0]    s1_exp,
  input  logic [K*PW-1:0]         s1_prod,
  output logic                    s2_valid,
  output logic                    s2_last,
  output logic                    s2_nan,
  output logic signed [XW-1:0]    s2_exp,
  output logic signed [SUM_W-1:0] s2_sum
);
  localparam logic signed [SUM_W-1:0] SUM_MAX = SUM_W'(K * (1 << (2*EW - 2)));
  localparam logic signed [SUM_W-1:0] SUM_MIN =
    SUM_W'(-(K * (1 << (EW - 1)) * ((1 << (EW - 1)) - 1)));

  logic signed [SUM_W-1:0] tot;

  always_comb begin
    tot = '0;
    for (int i = 0; i < K; i++) begin
      tot = tot + SUM_W'($signed(s1_prod[i*PW +: PW]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     s2_valid <= 1'b0;
    else if (en) s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s2_sum  <= tot;
      s2_exp  <= s1_exp;
      s2_nan  <= s1_nan;
      s2_last <= s1_last;
    end
  end

  // R3: the exact block sum stays within the full-range product bounds
  a_r3_block_range: assert property (@(posedge clk) disable iff (rst)
    s2_valid |-> (s2_sum <= SUM_MAX && s2_sum >= SUM_MIN));
endmodule

// File: rtl/mxdot_acc.sv
module mxdot_acc #(
  parameter int SUM_W = 21,
  parameter int ACC_W = 29,
  parameter int XW    = 10,
  localparam int SHW  = $clog2(ACC_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    s2_valid,
  input  logic                    s2_last,
  input  logic                    s2_nan,
  input  logic signed [XW-1:0]    s2_exp,
  input  logic signed [SUM_W-1:0] s2_sum,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_sum,
  output logic signed [XW-1:0]    out_exp,
  output logic                    out_nan
);
  localparam logic [XW:0] SH_MAX = (XW+1)'(ACC_W - 1);

  logic                    run_active, run_nan;
  logic signed [ACC_W-1:0] run_sum, bsum, n_sum;
  logic signed [XW-1:0]    run_exp, n_exp;
  logic                    n_nan, ge;
  logic signed [XW:0]      dx;
  logic [XW:0]             mag;
  logic [SHW-1:0]          sh;

  always_comb begin
    bsum = ACC_W'(s2_sum);
    dx   = {s2_exp[XW-1], s2_exp} - {run_exp[XW-1], run_exp};
    ge   = ~dx[XW];
    mag  = ge ? dx : -dx;
    sh   = (mag > SH_MAX) ? SHW'(ACC_W - 1) : mag[SHW-1:0];
    if (!run_active) begin
      n_sum = bsum;
      n_exp = s2_exp;
      n_nan = s2_nan;
    end else begin
      n_sum = ge ? (bsum + (run_sum >>> sh)) : ((bsum >>> sh) + run_sum);
      n_exp = ge ? s2_exp : run_exp;
      n_nan = s2_nan | run_nan;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      run_active <= 1'b0;
    end else if (en) begin
      out_valid <= s2_valid && s2_last;
      if (s2_valid) run_active <= !s2_last;
    end
  end

  always_ff @(posedge clk) begin
    if (en && s2_valid) begin
      if (s2_last) begin
        out_sum <= n_sum;
        out_exp <= n_exp;
        out_nan <= n_nan;
      end else begin
        run_sum <= n_sum;
        run_exp <= n_exp;
        run_nan <= n_nan;
      end
    end
  end

  // R6: a closing block emits, anything else leaves the output idle
  a_r6_emit: assert property (@(posedge clk) disable iff (rst)
    (en && s2_valid && s2_last) |=> out_valid);
  a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
    (en && !(s2_valid && s2_last)) |=> !out_valid);

  // R9: a stalled result does not move
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !en) |=> (out_valid && $stable(out_sum) && $stable(out_exp) && $stable(out_nan)));

  // R7: the running exponent never drops inside a group
  a_r7_max_exp: assert property (@(posedge clk) disable iff (rst)
    (en && s2_valid && !s2_last && run_active) |=> (run_exp >= $past(run_exp)));

  // R8: a NaN already in the group reaches the output
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (en && s2_valid && s2_last && run_active && run_nan) |=> out_nan);
endmodule

// File: rtl/mxdot_unit.sv
module mxdot_unit #(
  parameter int K     = 32,
  parameter int EW    = 8,
  parameter int SW    = 8,
  parameter int GUARD = 8,
  localparam int SUM_W = mxdot_pkg::sum_width(K, EW),
  localparam int ACC_W = SUM_W + GUARD,
  localparam int XW    = mxdot_pkg::exp_width(SW),
  localparam int PW    = 2 * EW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_last,
  input  logic [SW-1:0]    in_scale_a,
  input  logic [SW-1:0]    in_scale_b,
  input  logic [K*EW-1:0]  in_elem_a,
  input  logic [K*EW-1:0]  in_elem_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_sum,
  output logic [XW-1:0]    out_exp,
  output logic             out_nan
);
  logic en, in_fire;
  logic s1_valid, s1_last, s1_nan, s2_valid, s2_last, s2_nan;
  logic signed [XW-1:0]    s1_exp, s2_exp, acc_exp;
  logic [K*PW-1:0]         s1_prod;
  logic signed [SUM_W-1:0] s2_sum;
  logic signed [ACC_W-1:0] acc_sum;

  // whole pipeline advances unless a finished result is waiting
  assign en       = !out_valid || out_ready;
  assign in_ready = en;
  assign in_fire  = in_valid && en;
  assign out_sum  = acc_sum;
  assign out_exp  = acc_exp;

  mxdot_mul #(.K(K), .EW(EW), .SW(SW), .XW(XW)) u_mul (
    .clk(clk), .rst(rst), .en(en), .in_fire(in_fire), .in_last(in_last),
    .scale_a(in_scale_a), .scale_b(in_scale_b),
    .elem_a(in_elem_a), .elem_b(in_elem_b),
    .s1_valid(s1_valid), .s1_last(s1_last), .s1_nan(s1_nan),
    .s1_exp(s1_exp), .s1_prod(s1_prod));

  mxdot_sum #(.K(K), .EW(EW), .XW(XW), .SUM_W(SUM_W)) u_sum (
    .clk(clk), .rst(rst), .en(en),
    .s1_valid(s1_valid), .s1_last(s1_last), .s1_nan(s1_nan),
    .s1_exp(s1_exp), .s1_prod(s1_prod),
    .s2_valid(s2_valid), .s2_last(s2_last), .s2_nan(s2_nan),
    .s2_exp(s2_exp), .s2_sum(s2_sum));

  mxdot_acc #(.SUM_W(SUM_W), .ACC_W(ACC_W), .XW(XW)) u_acc (
    .clk(clk), .rst(rst), .en(en),
    .s2_valid(s2_valid), .s2_last(s2_last), .s2_nan(s2_nan),
    .s2_exp(s2_exp), .s2_sum(s2_sum),
    .out_valid(out_valid), .out_sum(acc_sum), .out_exp(acc_exp), .out_nan(out_nan));
endmodule

// File: tb/mxdot_unit_tb.sv
`timescale 1ns/1ps
module mxdot_unit_tb;
  localparam int K = 32;
  localparam int EW = 8;
  localparam int ACC_W = 29;
  localparam int XW = 10;
  // {pattern[2:0], scale_a[7:0], scale_b[7:0]}
  localparam logic [18:0] VEC [0:7] = '{
    {3'd0, 8'd127, 8'd127}, {3'd1, 8'd130, 8'd120},
    {3'd2, 8'd0,   8'd0  }, {3'd3, 8'd254, 8'd254},
    {3'd4, 8'd255, 8'd100}, {3'd5, 8'd60,  8'd255},
    {3'd0, 8'd254, 8'd1  }, {3'd1, 8'd200, 8'd9  }};

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [7:0] in_scale_a = '0, in_scale_b = '0;
  logic [K*EW-1:0] in_elem_a = '0, in_elem_b = '0;
  logic in_ready, out_valid, out_nan;
  logic [ACC_W-1:0] out_sum;
  logic [XW-1:0] out_exp;
  int n_chk = 0, n_bad = 0, n_out = 0;

  always #4 clk = ~clk;

  mxdot_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
    .in_scale_a(in_scale_a), .in_scale_b(in_scale_b),
    .in_elem_a(in_elem_a), .in_elem_b(in_elem_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_exp(out_exp), .out_nan(out_nan));

  always @(posedge clk) if (out_valid && out_ready) n_out++;

  function automatic logic [7:0] elem(int p, bit side, int i);
    int v;
    case (p)
      0: v = side ? 3 * i - 50 : i - 16;
      1: v = -128;
      2: v = side ? 127 : -128;
      3: v = side ? ((i % 2) ? 127 : -128) : ((i % 2) ? 127 : -127);
      4: v = (i == 31) ? (side ? 9 : -7) : 0;
      default: v = (i == 0) ? (side ? -3 : 5) : 0;
    endcase
    return 8'(v);
  endfunction

  function automatic longint dot(int p);
    longint s = 0;
    for (int i = 0; i < K; i++)
      s += longint'($signed(elem(p, 1'b0, i))) * longint'($signed(elem(p, 1'b1, i)));
    return s;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the accepting edge
  task automatic send(int p, int sa, int sb, bit last);
    in_scale_a = 8'(sa);
    in_scale_b = 8'(sb);
    in_last    = last;
    for (int i = 0; i < K; i++) begin
      in_elem_a[i*EW +: EW] = elem(p, 1'b0, i);
      in_elem_b[i*EW +: EW] = elem(p, 1'b1, i);
    end
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic longint sum_s();
    return longint'($signed(out_sum));
  endfunction
  function automatic longint exp_s();
    return longint'($signed(out_exp));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R5 actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 out_valid after reset", out_valid, 0);
    chk("R10 in_ready after reset", in_ready, 1);

    // single-block table
    for (int v = 0; v < 8; v++) begin
      int p = int'(VEC[v][18:16]);
      int sa = int'(VEC[v][15:8]);
      int sb = int'(VEC[v][7:0]);
      bit nan = (sa == 255) || (sb == 255);
      string tag = (p == 1 || p == 2) ? "R3 full-range sum" : "R1 sum";
      send(p, sa, sb, 1'b1);
      @(negedge clk);
      chk("R5 not valid after second edge", out_valid, 0);
      @(negedge clk);
      chk("R5 valid after third edge", out_valid, 1);
      chk("R4 nan flag", out_nan, nan);
      if (!nan) begin
        chk(tag, sum_s(), dot(p));
        chk("R2 exponent", exp_s(), sa + sb - 254);
      end
      @(negedge clk);
    end

    // R7: new block has the smaller exponent
    n_out = 0;
    send(5, 130, 127, 1'b0);
    send(4, 127, 127, 1'b1);
    repeat (2) @(negedge clk);
    chk("R7 smaller new sum", sum_s(), (dot(4) >>> 3) + dot(5));
    chk("R7 smaller new exp", exp_s(), 3);
    @(negedge clk);
    chk("R6 one output per group", n_out, 1);

    // R7: new block has the larger exponent
    n_out = 0;
    send(1, 127, 127, 1'b0);
    send(5, 128, 128, 1'b1);
    repeat (2) @(negedge clk);
    chk("R7 larger new sum", sum_s(), (dot(1) >>> 2) + dot(5));
    chk("R7 larger new exp", exp_s(), 2);
    @(negedge clk);
    chk("R6 one output per group", n_out, 1);

    // R7: equal exponents, three blocks, exact
    n_out = 0;
    send(0, 127, 127, 1'b0);
    send(2, 127, 127, 1'b0);
    send(3, 127, 127, 1'b1);
    repeat (2) @(negedge clk);
    chk("R7 equal exp exact sum", sum_s(), dot(0) + dot(2) + dot(3));
    chk("R7 equal exp", exp_s(), 0);
    @(negedge clk);
    chk("R6 three blocks one output", n_out, 1);

    // R8: NaN sticky within a group, clear in the next
    send(5, 255, 127, 1'b0);
    send(4, 127, 127, 1'b1);
    repeat (2) @(negedge clk);
    chk("R8 sticky nan", out_nan, 1);
    @(negedge clk);
    send(4, 127, 127, 1'b1);
    repeat (2) @(negedge clk);
    chk("R8 next group clear nan", out_nan, 0);
    chk("R8 next group sum", sum_s(), dot(4));
    @(negedge clk);

    // R10: reset drops a partial group
    send(1, 127, 127, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R10 in_ready after mid-group reset", in_ready, 1);
    send(5, 127, 127, 1'b1);
    repeat (2) @(negedge clk);
    chk("R10 fresh group sum", sum_s(), dot(5));
    chk("R10 fresh group exp", exp_s(), 0);
    @(negedge clk);

    // R9: backpressure
    n_out = 0;
    out_ready = 1'b0;
    send(5, 127, 127, 1'b1);
    repeat (2) @(negedge clk);
    chk("R9 valid while stalled", out_valid, 1);
    chk("R9 in_ready low while stalled", in_ready, 0);
    repeat (2) @(negedge clk);
    chk("R9 still valid", out_valid, 1);
    chk("R9 sum held", sum_s(), dot(5));
    chk("R9 nothing taken yet", n_out, 0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 result taken once", n_out, 1);
    chk("R9 valid drops after take", out_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule